// File: doc/BRIEF.md
# Skewed Multi-Bank Matrix Memory

This block stores a 4x4 matrix of small elements. The elements are spread over five single-port-read memory banks in a skewed pattern. Because of the skew, four processing lanes can fetch a complete row, a complete column or the main diagonal in one access, and no two lanes ever need the same bank. Element (r, c) lives in bank (r + 2*c) mod 5 at word r. Any row, any column and the main diagonal therefore land in four different banks, and the fifth bank sits idle during that access.

Elements are loaded one at a time through a write port addressed by row and column. A read request names an access mode and an index. From these an address generator derives one word address per bank, plus the bank that feeds each lane. A crossbar after the banks puts the four fetched elements back in lane order, so lane k always receives element k of the selected slice.

Top module: `skew_matrix_mem`

## Requirements
- R1: Every read touches exactly four distinct banks, so no bank is asked for two words in the same access, and the fifth bank is not enabled.
- R2: With rd_mode = 2'b00, lane k (rd_data bits [8k+7:8k]) returns element (rd_idx, k).
- R3: With rd_mode = 2'b01, lane k returns element (k, rd_idx).
- R4: With rd_mode = 2'b10, lane k returns diagonal element (k, k), and rd_idx has no effect.
- R5: rd_mode = 2'b11 behaves exactly like rd_mode = 2'b00.
- R6: rd_data and rd_valid update at the first rising clock edge after a request is presented. rd_valid is high in exactly the cycle that follows a cycle with rd_en high.
- R7: While rd_en is low, rd_data keeps its last value.
- R8: A write with wr_en high stores wr_data at (wr_row, wr_col) and leaves every other element unchanged.
- R9: When a read and a write to the same element occur in the same cycle, the read returns the value held before the write.
- R10: After reset, rd_valid is 0, rd_data is 0 and every matrix element reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one element |
| wr_row | input | 2 | Row of the element written |
| wr_col | input | 2 | Column of the element written |
| wr_data | input | 8 | Element value written |
| rd_en | input | 1 | Start a parallel read |
| rd_mode | input | 2 | 00 row, 01 column, 10 diagonal, 11 row |
| rd_idx | input | 2 | Row or column number; unused for diagonal |
| rd_valid | output | 1 | rd_data carries the result of the previous cycle's read |
| rd_data | output | 32 | Four lanes of 8 bits, lane k at bits [8k+7:8k] |

## Verification
The matrix is filled with distinct pseudo-random values, so an element that comes out of the wrong bank, the wrong word or the wrong lane always shows up as a different value. All four rows and all four columns are read to exercise every skew offset. Diagonal reads use two different index values to show that the index has no effect, and mode 11 reads are compared against the matching row reads. Directed cases cover the all-zero state after reset, a write made in the same cycle as a read of the same element, a single overwrite with its neighbours checked for being left alone, and output hold while no read is requested.

// File: rtl/skew_mem_pkg.sv
package skew_mem_pkg;
    localparam int DIM    = 4;
    localparam int NBANK  = DIM + 1;
    localparam int IDX_W  = $clog2(DIM);
    localparam int BANK_W = $clog2(NBANK);
    localparam int SKEW   = 2;

    typedef enum logic [1:0] {
        ACC_ROW     = 2'b00,
        ACC_COL     = 2'b01,
        ACC_DIAG    = 2'b10,
        ACC_ROW_ALT = 2'b11
    } acc_mode_e;

    // bank holding element (r, c)
    function automatic logic [BANK_W-1:0] bank_of(input logic [IDX_W-1:0] r,
                                                  input logic [IDX_W-1:0] c);
        int s;
        s = (int'(r) + SKEW * int'(c)) % NBANK;
        return BANK_W'(s);
    endfunction
endpackage

// File: rtl/skew_addr_gen.sv
module skew_addr_gen
    import skew_mem_pkg::*;
(
    input  logic [1:0]                        mode,
    input  logic [IDX_W-1:0]                  idx,
    output logic [NBANK-1:0][IDX_W-1:0]       bank_addr,
    output logic [NBANK-1:0]                  bank_used,
    output logic [DIM-1:0][BANK_W-1:0]        lane_bank
);
    always_comb begin
        bank_addr = '0;
        bank_used = '0;
        lane_bank = '0;
        for (int k = 0; k < DIM; k++) begin
            logic [IDX_W-1:0] r, c;
            case (acc_mode_e'(mode))
                ACC_COL:  begin r = IDX_W'(k); c = idx;        end
                ACC_DIAG: begin r = IDX_W'(k); c = IDX_W'(k);  end
                default:  begin r = idx;       c = IDX_W'(k);  end
            endcase
            lane_bank[k]            = bank_of(r, c);
            bank_used[lane_bank[k]] = 1'b1;
            bank_addr[lane_bank[k]] = r;
        end
    end
endmodule

// File: rtl/skew_bank.sv
module skew_bank #(
    parameter int ELEM_W = 8,
    parameter int DEPTH  = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [ELEM_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [ELEM_W-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][ELEM_W-1:0] mem;
        logic [ELEM_W-1:0]            rdata;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) st_d.rdata = st_q.mem[rd_addr];   // old value on collision
        if (wr_en) st_d.mem[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    // R7: an idle bank keeps its output word
    assert_bank_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/skew_xbar.sv
module skew_xbar
    import skew_mem_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic [NBANK-1:0][ELEM_W-1:0] bank_rdata,
    input  logic [DIM-1:0][BANK_W-1:0]   lane_sel,
    output logic [DIM*ELEM_W-1:0]        lane_data
);
    always_comb begin
        lane_data = '0;
        for (int k = 0; k < DIM; k++) begin
            if (int'(lane_sel[k]) < NBANK)
                lane_data[k*ELEM_W +: ELEM_W] = bank_rdata[lane_sel[k]];
        end
    end
endmodule

// File: rtl/skew_matrix_mem.sv
module skew_matrix_mem
    import skew_mem_pkg::*;
#(
    parameter int ELEM_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_row,
    input  logic [IDX_W-1:0]        wr_col,
    input  logic [ELEM_W-1:0]       wr_data,
    input  logic                    rd_en,
    input  logic [1:0]              rd_mode,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_valid,
    output logic [DIM*ELEM_W-1:0]   rd_data
);
    typedef struct packed {
        logic [DIM-1:0][BANK_W-1:0] lane_sel;
        logic                       valid;
    } top_state_t;

    top_state_t top_d, top_q;

    logic [NBANK-1:0][IDX_W-1:0]  bank_addr;
    logic [NBANK-1:0]             bank_used;
    logic [DIM-1:0][BANK_W-1:0]   lane_bank;
    logic [NBANK-1:0]             bank_rd_en;
    logic [NBANK-1:0]             bank_wr_en;
    logic [NBANK-1:0][ELEM_W-1:0] bank_rdata;
    logic [BANK_W-1:0]            wr_bank;

    skew_addr_gen u_addr (
        .mode      (rd_mode),
        .idx       (rd_idx),
        .bank_addr (bank_addr),
        .bank_used (bank_used),
        .lane_bank (lane_bank)
    );

    assign wr_bank = bank_of(wr_row, wr_col);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_rd_en[b] = rd_en && bank_used[b];
        assign bank_wr_en[b] = wr_en && (wr_bank == BANK_W'(b));
        skew_bank #(.ELEM_W(ELEM_W), .DEPTH(DIM)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr_en[b]),
            .wr_addr (wr_row),
            .wr_data (wr_data),
            .rd_en   (bank_rd_en[b]),
            .rd_addr (bank_addr[b]),
            .rd_data (bank_rdata[b])
        );
    end

    always_comb begin
        top_d       = top_q;
        top_d.valid = rd_en;
        if (rd_en) top_d.lane_sel = lane_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    skew_xbar #(.ELEM_W(ELEM_W)) u_xbar (
        .bank_rdata (bank_rdata),
        .lane_sel   (top_q.lane_sel),
        .lane_data  (rd_data)
    );

    assign rd_valid = top_q.valid;

    // R1: four distinct banks per access, spare bank idle
    assert_conflict_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ($countones(bank_rd_en) == DIM));
    assert_idle_banks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (bank_rd_en == '0));
    // R6: valid follows the request by one edge
    assert_valid_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    assert_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
    // R7: output held without a request
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/skew_matrix_mem_tb.sv
module skew_matrix_mem_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // {mode, idx}
    localparam logic [3:0] VEC [NV] = '{
        4'b00_00, 4'b00_01, 4'b00_10, 4'b00_11,
        4'b01_00, 4'b01_01, 4'b01_10, 4'b01_11,
        4'b10_00, 4'b10_11, 4'b11_10, 4'b11_00
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_row = '0, wr_col = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_mode = '0, rd_idx = '0;
    logic        rd_valid;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] model [4][4];

    always #(CLK_PERIOD/2) clk = ~clk;

    skew_matrix_mem dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
        .rd_en(rd_en), .rd_mode(rd_mode), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] lane_exp(input logic [1:0] m, input logic [1:0] idx,
                                            input int k);
        case (m)
            2'b01:   return model[k][idx];
            2'b10:   return model[k][k];
            default: return model[idx][k];
        endcase
    endfunction

    function automatic logic [31:0] slice_exp(input logic [1:0] m, input logic [1:0] idx);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[k*8 +: 8] = lane_exp(m, idx, k);
        return v;
    endfunction

    task automatic write_elem(input logic [1:0] r, input logic [1:0] c, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = r; wr_col = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[r][c] = d;
    endtask

    // issue a read and check it one edge later
    task automatic read_check(input logic [1:0] m, input logic [1:0] idx, input string req);
        logic [31:0] e;
        e = slice_exp(m, idx);
        @(negedge clk);
        rd_en = 1'b1; rd_mode = m; rd_idx = idx;
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, {req, " R6 valid"}, {31'd0, rd_valid}, 32'd1);
        check(rd_data === e, req, rd_data, e);
    endtask

    initial begin
        logic [7:0] x;
        logic [31:0] held;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) model[r][c] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(rd_valid === 1'b0, "R10 valid after reset", {31'd0, rd_valid}, 32'd0);
        check(rd_data === 32'd0, "R10 data after reset", rd_data, 32'd0);
        read_check(2'b00, 2'd2, "R10 zero row");
        read_check(2'b01, 2'd1, "R10 zero col");

        // fill with distinct pseudo-random values
        x = 8'h5B;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                x = x * 8'd37 + 8'd11;
                write_elem(2'(r), 2'(c), x);
            end

        // table walk: R2 rows, R3 columns, R4 diagonal, R5 alt row mode
        for (int v = 0; v < NV; v++) begin
            case (VEC[v][3:2])
                2'b00:   read_check(VEC[v][3:2], VEC[v][1:0], "R2 row read");
                2'b01:   read_check(VEC[v][3:2], VEC[v][1:0], "R3 column read");
                2'b10:   read_check(VEC[v][3:2], VEC[v][1:0], "R4 diagonal read");
                default: read_check(VEC[v][3:2], VEC[v][1:0], "R5 mode 11 row read");
            endcase
        end

        // R6 / R7: valid drops and data held with no request
        held = rd_data;
        @(negedge clk);
        check(rd_valid === 1'b0, "R6 valid low when idle", {31'd0, rd_valid}, 32'd0);
        check(rd_data === held, "R7 data held when idle", rd_data, held);
        repeat (3) @(negedge clk);
        check(rd_data === held, "R7 data held several cycles", rd_data, held);

        // R9: read and write same element in one cycle returns old value
        begin
            logic [31:0] old_row;
            old_row = slice_exp(2'b00, 2'd1);
            @(negedge clk);
            rd_en = 1'b1; rd_mode = 2'b00; rd_idx = 2'd1;
            wr_en = 1'b1; wr_row = 2'd1; wr_col = 2'd2; wr_data = ~model[1][2];
            @(negedge clk);
            rd_en = 1'b0; wr_en = 1'b0;
            model[1][2] = wr_data;
            check(rd_data === old_row, "R9 read before write", rd_data, old_row);
        end
        // R8: new value visible, neighbours untouched
        read_check(2'b00, 2'd1, "R8 row after overwrite");
        read_check(2'b01, 2'd2, "R8 column after overwrite");
        write_elem(2'd3, 2'd3, 8'hC3);
        read_check(2'b10, 2'd1, "R8 diagonal after overwrite");
        read_check(2'b00, 2'd3, "R8 row 3 after overwrite");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule